// File: doc/BRIEF.md
# Test Observation Multiplexer with Divider Bypass

This block picks which internal node is driven onto a single test pin of a clock synthesizer. A 3-bit selection code chooses a static level, the reference clock, the output clock or a quarter of it, the tail bit of the serial configuration shift register, or the pulse stream of a programmable loop counter. The loop counter is part of the block: it counts rising edges of the divider clock and emits one pulse per M edges.

One code puts the block into bypass. In bypass the divider clock that feeds the loop counter and the downstream output divider comes from the slow serial clock instead of the oscillator clock. The loop counter output then appears on the test pin. Source changes go through a selector that only moves while both candidate clocks are low, so no shortened high phase reaches the dividers. A low level on the parallel-load input holds the selection at its reset code.

All clock-like inputs are sampled by the block's own fast clock `clk` and treated as levels. This suits low-speed observation and board-level test.

Top module: `test_obs_mux`

## Requirements
- R1: After reset, and for every cycle that `pload_n` is low, the selection is code 000 and `test_out` follows `sr_tail`; `t_load` has no effect while `pload_n` is low.
- R2: When `t_load` is high with `pload_n` high, `t_code` is captured; code 001 drives `test_out` high and code 101 drives it low.
- R3: Code 010 routes `ref_clk`, code 100 routes `fout_clk`, and code 111 routes `fout_div4` to `test_out`.
- R4: With code 011 and M >= 2, `test_out` carries exactly one pulse for every M rising edges of the oscillator clock `vco_clk`, counting from reset.
- R5: Code 110 (bypass) makes `div_clk` follow `ser_clk` instead of `vco_clk`, and `test_out` carries the loop counter pulses counted on `ser_clk` edges.
- R6: The divider clock source changes only in a cycle where the sampled `vco_clk` and `ser_clk` are both low; a pending change waits while either is high.
- R7: An M value of 0 or 1 passes the selected divider clock straight to the loop counter output, so every source edge gives one output pulse.
- R8: For M >= 2 each loop counter pulse lasts exactly one `clk` cycle.
- R9: Any input level reaches `test_out` and `div_clk` two `clk` cycles after it is sampled (one sampling stage, one output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload_n | input | 1 | Parallel-load level; low forces selection code 000 |
| t_load | input | 1 | Capture strobe for `t_code` |
| t_code | input | 3 | Test selection code |
| m_value | input | 9 | Loop counter modulus |
| ref_clk | input | 1 | Reference clock level |
| vco_clk | input | 1 | Oscillator clock level |
| ser_clk | input | 1 | Serial clock level, bypass source |
| sr_tail | input | 1 | Last bit of the configuration shift register |
| fout_clk | input | 1 | Output clock level |
| fout_div4 | input | 1 | Output clock divided by four |
| test_out | output | 1 | Observed node |
| div_clk | output | 1 | Divider clock to the output divider |

## Verification
The assertions assume every clock-like input holds each level for at least two `clk` cycles, so each rising edge is seen once. They also assume `m_value` stays stable while pulses are counted and `t_code` is steady when `t_load` strobes. The stimulus drives all inputs on the falling edge of `clk`, toggles the source clocks with four-cycle half periods, and changes `m_value` only under reset. Source changes are requested with the clocks held low or high on purpose, so the wait rule of the selector is exercised in both directions.

// File: rtl/tmux_pkg.sv
package tmux_pkg;
  typedef enum logic [2:0] {
    TS_TAIL   = 3'b000,
    TS_HIGH   = 3'b001,
    TS_REF    = 3'b010,
    TS_MCNT   = 3'b011,
    TS_FOUT   = 3'b100,
    TS_LOW    = 3'b101,
    TS_BYPASS = 3'b110,
    TS_FDIV4  = 3'b111
  } tsel_e;

  // positions in the sampled input vector
  localparam int unsigned IX_REF   = 0;
  localparam int unsigned IX_VCO   = 1;
  localparam int unsigned IX_SER   = 2;
  localparam int unsigned IX_TAIL  = 3;
  localparam int unsigned IX_FOUT  = 4;
  localparam int unsigned IX_FDIV4 = 5;
  localparam int unsigned NUM_TAPS = 6;
endpackage

// File: rtl/tmux_sampler.sv
module tmux_sampler #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= d[g];
    end
  end
endmodule

// File: rtl/tmux_srcsel.sv
module tmux_srcsel (
  input  logic clk,
  input  logic rst_n,
  input  logic want_alt,
  input  logic pri,
  input  logic alt,
  output logic use_alt,
  output logic lvl,
  output logic clk_out
);
  // move only while both candidates sit low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          use_alt <= 1'b0;
    else if (!pri && !alt) use_alt <= want_alt;
  end

  assign lvl = use_alt ? alt : pri;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= lvl;
  end
endmodule

// File: rtl/tmux_mcount.sv
module tmux_mcount #(
  parameter int unsigned MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src,
  input  logic [MW-1:0] m_value,
  output logic          pulse
);
  localparam logic [MW-1:0] ONE = MW'(1);

  logic          prev;
  logic [MW-1:0] cnt;
  logic          rise;
  logic          pass;
  logic          last;

  assign rise = src & ~prev;
  assign pass = (m_value <= ONE);
  assign last = (cnt >= m_value - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      prev <= src;
      if (pass) begin
        cnt   <= '0;
        pulse <= src;
      end else begin
        pulse <= rise && last;
        if (rise) cnt <= last ? '0 : cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/test_obs_mux.sv
module test_obs_mux
  import tmux_pkg::*;
#(
  parameter int unsigned MW = 9,
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic          t_load,
  input  logic [TW-1:0] t_code,
  input  logic [MW-1:0] m_value,
  input  logic          ref_clk,
  input  logic          vco_clk,
  input  logic          ser_clk,
  input  logic          sr_tail,
  input  logic          fout_clk,
  input  logic          fout_div4,
  output logic          test_out,
  output logic          div_clk
);
  logic [NUM_TAPS-1:0] raw;
  logic [NUM_TAPS-1:0] smp;
  tsel_e               sel_q;
  logic                use_alt;
  logic                div_lvl;
  logic                m_pulse;
  logic                mux_d;
  logic                smp_vco;
  logic                smp_ser;

  always_comb begin
    raw           = '0;
    raw[IX_REF]   = ref_clk;
    raw[IX_VCO]   = vco_clk;
    raw[IX_SER]   = ser_clk;
    raw[IX_TAIL]  = sr_tail;
    raw[IX_FOUT]  = fout_clk;
    raw[IX_FDIV4] = fout_div4;
  end

  tmux_sampler #(.W(NUM_TAPS)) u_smp (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(smp)
  );

  assign smp_vco = smp[IX_VCO];
  assign smp_ser = smp[IX_SER];

  // selection latch, held at the tail code while parallel load is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= TS_TAIL;
    else if (!pload_n) sel_q <= TS_TAIL;
    else if (t_load) sel_q <= tsel_e'(t_code);
  end

  tmux_srcsel u_src (
    .clk(clk), .rst_n(rst_n), .want_alt(sel_q == TS_BYPASS),
    .pri(smp_vco), .alt(smp_ser),
    .use_alt(use_alt), .lvl(div_lvl), .clk_out(div_clk)
  );

  tmux_mcount #(.MW(MW)) u_mcnt (
    .clk(clk), .rst_n(rst_n), .src(div_lvl), .m_value(m_value), .pulse(m_pulse)
  );

  always_comb begin
    unique case (sel_q)
      TS_TAIL:   mux_d = smp[IX_TAIL];
      TS_HIGH:   mux_d = 1'b1;
      TS_REF:    mux_d = smp[IX_REF];
      TS_MCNT:   mux_d = m_pulse;
      TS_FOUT:   mux_d = smp[IX_FOUT];
      TS_LOW:    mux_d = 1'b0;
      TS_BYPASS: mux_d = m_pulse;
      TS_FDIV4:  mux_d = smp[IX_FDIV4];
      default:   mux_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_out <= 1'b0;
    else        test_out <= mux_d;
  end
endmodule

// File: rtl/test_obs_mux_chk.sv
module test_obs_mux_chk #(
  parameter int unsigned MW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pload_n,
  input logic [2:0]    sel_q,
  input logic          use_alt,
  input logic          smp_vco,
  input logic          smp_ser,
  input logic          m_pulse,
  input logic [MW-1:0] m_value,
  input logic          test_out,
  input logic          div_clk
);
  assert_pload_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_n |=> (sel_q == 3'b000));

  assert_high_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 3'b001) |=> test_out);

  assert_low_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 3'b101) |=> !test_out);

  assert_bypass_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (use_alt && sel_q == 3'b110) |=> (test_out == $past(m_pulse)));

  assert_switch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(use_alt) |-> (!$past(smp_vco) && !$past(smp_ser)));

  assert_div_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !use_alt |=> (div_clk == $past(smp_vco)));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pulse && m_value > 1) |=> (!m_pulse || m_value <= 1));
endmodule

bind test_obs_mux test_obs_mux_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .sel_q(sel_q),
  .use_alt(use_alt), .smp_vco(smp_vco), .smp_ser(smp_ser),
  .m_pulse(m_pulse), .m_value(m_value), .test_out(test_out), .div_clk(div_clk)
);

// File: tb/test_obs_mux_bench.sv
module test_obs_mux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pload_n = 1'b1;
  logic       t_load = 1'b0;
  logic [2:0] t_code = 3'b000;
  logic [8:0] m_value = 9'd5;
  logic       ref_clk = 0, vco_clk = 0, ser_clk = 0, sr_tail = 0, fout_clk = 0, fout_div4 = 0;
  logic       test_out, div_clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  test_obs_mux u_test_obs_mux (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .t_load(t_load), .t_code(t_code),
    .m_value(m_value), .ref_clk(ref_clk), .vco_clk(vco_clk), .ser_clk(ser_clk),
    .sr_tail(sr_tail), .fout_clk(fout_clk), .fout_div4(fout_div4),
    .test_out(test_out), .div_clk(div_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [8:0] m);
    @(negedge clk);
    rst_n = 0; m_value = m;
    {ref_clk, vco_clk, ser_clk, sr_tail, fout_clk, fout_div4} = '0;
    pload_n = 1; t_load = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
  endtask

  task automatic load_code(input logic [2:0] c);
    t_code = c; t_load = 1;
    @(negedge clk);
    t_load = 0;
  endtask

  // toggle one source (half period 4 cycles), count rises on test_out and div_clk
  task automatic toggle_count(input bit on_ser, input int edges,
                              output int t_rises, output int d_rises, output int max_run);
    logic pt, pd;
    int run;
    pt = test_out; pd = div_clk; t_rises = 0; d_rises = 0; max_run = 0; run = 0;
    for (int i = 0; i < edges * 8 + 12; i++) begin
      if (test_out && !pt) t_rises++;
      if (div_clk && !pd) d_rises++;
      run = test_out ? run + 1 : 0;
      if (run > max_run) max_run = run;
      pt = test_out; pd = div_clk;
      if (on_ser) ser_clk = (i < edges * 8) && ((i % 8) < 4);
      else        vco_clk = (i < edges * 8) && ((i % 8) < 4);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_tail;
    do_reset(9'd5);
    check("R1 reset test_out", test_out, 0);
    sr_tail = 1; wait_n(3);
    check("R1 tail high after reset", test_out, 1);
    load_code(3'b001); wait_n(3);
    check("R2 code 001 high", test_out, 1);
    sr_tail = 0; pload_n = 0; wait_n(3);
    check("R1 pload low shows tail", test_out, 0);
    load_code(3'b001); wait_n(3);
    check("R1 t_load ignored under pload", test_out, 0);
    sr_tail = 1; wait_n(3);
    check("R1 tail follows under pload", test_out, 1);
    pload_n = 1; wait_n(2);
  endtask

  task automatic t_static_and_clocks;
    do_reset(9'd5);
    load_code(3'b101); wait_n(3);
    check("R2 code 101 low", test_out, 0);
    load_code(3'b010); ref_clk = 1; wait_n(3);
    check("R3 ref high", test_out, 1);
    ref_clk = 0; wait_n(3);
    check("R3 ref low", test_out, 0);
    load_code(3'b100); fout_clk = 1; wait_n(3);
    check("R3 fout high", test_out, 1);
    load_code(3'b111); fout_div4 = 0; wait_n(3);
    check("R3 fdiv4 low while fout high", test_out, 0);
    fout_div4 = 1; wait_n(3);
    check("R3 fdiv4 high", test_out, 1);
  endtask

  task automatic t_latency;
    do_reset(9'd5);
    load_code(3'b010); wait_n(3);
    ref_clk = 1;
    @(negedge clk);
    check("R9 not yet after 1 cycle", test_out, 0);
    @(negedge clk);
    check("R9 visible after 2 cycles", test_out, 1);
  endtask

  task automatic t_mcount_vco;
    int tr, dr, mr;
    do_reset(9'd5);
    load_code(3'b011); wait_n(2);
    toggle_count(1'b0, 20, tr, dr, mr);
    check("R4 pulses for 20 vco edges M=5", tr, 4);
    check("R8 pulse width one cycle", mr, 1);
    check("R9 div_clk follows vco", dr, 20);
  endtask

  task automatic t_bypass;
    int tr, dr, mr;
    do_reset(9'd7);
    load_code(3'b110); wait_n(3);
    toggle_count(1'b1, 21, tr, dr, mr);
    check("R5 bypass pulses 21 ser edges M=7", tr, 3);
    check("R5 div_clk follows ser", dr, 21);
    toggle_count(1'b0, 6, tr, dr, mr);
    check("R5 vco ignored in bypass", dr, 0);
  endtask

  task automatic t_passthrough;
    int tr, dr, mr;
    do_reset(9'd1);
    load_code(3'b110); wait_n(3);
    toggle_count(1'b1, 9, tr, dr, mr);
    check("R7 M=1 passes every edge", tr, 9);
    do_reset(9'd0);
    load_code(3'b110); wait_n(3);
    toggle_count(1'b1, 5, tr, dr, mr);
    check("R7 M=0 passes every edge", tr, 5);
  endtask

  task automatic t_glitch_free;
    do_reset(9'd5);
    vco_clk = 1; wait_n(3);
    check("R6 div_clk on vco", div_clk, 1);
    load_code(3'b110); wait_n(4);
    check("R6 switch waits while vco high", div_clk, 1);
    vco_clk = 0; wait_n(3);
    ser_clk = 1; wait_n(3);
    check("R6 switched to ser after both low", div_clk, 1);
    ser_clk = 0; vco_clk = 1; wait_n(3);
    check("R6 vco no longer routed", div_clk, 0);
    ser_clk = 1; vco_clk = 0;
    load_code(3'b001); wait_n(4);
    check("R6 return waits while ser high", div_clk, 1);
    ser_clk = 0; wait_n(3);
    vco_clk = 1; wait_n(3);
    check("R6 back on vco", div_clk, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_tail();
    t_static_and_clocks();
    t_latency();
    t_mcount_vco();
    t_bypass();
    t_passthrough();
    t_glitch_free();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule